// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 96 pins. Every per-pin feature is stored as a vector spread over consecutive 32-bit words. The features are direction, output data, interrupt enable, interrupt polarity, interrupt type and pending status. Software programs it over a simple 32-bit register bus with separate read and write strobes. Each pin presents an output value and an output enable to its pad, and takes the pad's input value.

Pad inputs are synchronized and then compared against each pin's polarity and type to detect an active level or an active edge. Detected events latch into a sticky status bit, which software acknowledges by writing a one to it. The status bits of enabled pins are combined into a single registered interrupt request.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n of a feature is held at bit (n mod 32) of the word at that feature's byte address plus (n div 32)*4. The default feature base addresses are: output enable 0x00, output data 0x08, interrupt enable 0x18, polarity 0x38, type 0x40, status 0x48. Written configuration words read back unchanged.
- R2: After reset every register reads zero, and `pad_oe`, `pad_out` and `irq` are low.
- R3: Bit n of the output-enable feature appears on `pad_oe[n]` and bit n of the output-data feature on `pad_out[n]`, from the clock edge that captures the write.
- R4: Bits at or above NPINS read as zero and ignore writes. A word address that maps to no implemented word, or an address with nonzero low two bits, reads as zero.
- R5: With type bit 1 (edge), polarity 0 detects a rising input and polarity 1 a falling input. A detected edge sets the pin's sticky status bit on the third clock edge after the input change, and the opposite edge does not set it.
- R6: With type bit 0 (level), polarity 0 treats high as active and polarity 1 treats low as active. The status bit is set while the active level is present, so a clear issued while the level persists leaves the bit set.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R8: `irq` is the registered OR over all pins of status AND enable. It rises one cycle after the status bit does, and stays low for pins whose enable is 0.
- R9: Read data is registered. It is valid in the cycle after `rd_en` is sampled and is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | NPINS | Pad input values |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
An input change reaches the status bit on the third clock edge, and `irq` follows on the fourth. The bench samples `irq` at a falling edge after exactly three and four rising edges, expecting low and then high. Register writes take effect at the capturing edge, and read data appears one edge after the read strobe. Every read is therefore sampled at the falling edge that follows its single rising edge. Every pin of a 40-pin build is swept through all four type and polarity combinations. The expected status words are computed from the pin index.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned MAX_PINS  = 96;
   localparam int unsigned NFEAT     = 6;
   localparam int unsigned NCFG      = 5;

   typedef enum int unsigned {
      FT_OE   = 0,
      FT_DATA = 1,
      FT_IEN  = 2,
      FT_POL  = 3,
      FT_TYPE = 4,
      FT_STAT = 5
   } feat_e;

   function automatic bit windows_apart(input int unsigned a, input int unsigned b,
                                        input int unsigned span);
      return ((a + span) <= b) || ((b + span) <= a);
   endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned NPINS = 57
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] lvl,
   output logic [NPINS-1:0] lvl_d
);
   logic [NPINS-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         lvl    <= '0;
         lvl_d  <= '0;
      end else begin
         meta_q <= pad_in;
         lvl    <= meta_q;
         lvl_d  <= lvl;
      end
   end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int unsigned NPINS = 57
) (
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] lvl_d,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] typ,
   output logic [NPINS-1:0] evt
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic act_now;
      logic act_old;
      assign act_now = lvl[i] ^ pol[i];
      assign act_old = lvl_d[i] ^ pol[i];
      assign evt[i]  = typ[i] ? (act_now & ~act_old) : act_now;
   end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS  = 57,
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned FEAT_BASE [NFEAT] = '{32'h00, 32'h08, 32'h18, 32'h38, 32'h40, 32'h48}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [NPINS-1:0]  evt,
   output logic [NPINS-1:0]  oe,
   output logic [NPINS-1:0]  dout,
   output logic [NPINS-1:0]  ien,
   output logic [NPINS-1:0]  pol,
   output logic [NPINS-1:0]  typ,
   output logic [NPINS-1:0]  stat
);
   localparam int unsigned NWORDS = (NPINS + WORD_BITS - 1) / WORD_BITS;
   localparam int unsigned WA_W   = ADDR_W - 2;

   logic [NFEAT-1:0][NWORDS-1:0] hit;
   logic [NPINS-1:0] cfg_q [NCFG];
   logic [NPINS-1:0] stat_q;
   logic [NPINS-1:0] view [NFEAT];
   logic [NPINS-1:0] wsel [NFEAT];
   logic [NPINS-1:0] wval;
   logic [31:0]      rd_word;
   logic [31:0]      rdata_q;

   for (genvar f = 0; f < NFEAT; f++) begin : g_feat
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         assign hit[f][w] = (addr[1:0] == 2'b00) &&
                            (addr[ADDR_W-1:2] == WA_W'((FEAT_BASE[f] >> 2) + w));
      end
      for (genvar i = 0; i < NPINS; i++) begin : g_bit
         assign wsel[f][i] = wr_en && hit[f][i / WORD_BITS];
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_wval
      assign wval[i] = wdata[i % WORD_BITS];
   end

   for (genvar f = 0; f < NCFG; f++) begin : g_view
      assign view[f] = cfg_q[f];
   end
   assign view[FT_STAT] = stat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int f = 0; f < NCFG; f++) cfg_q[f] <= '0;
         stat_q <= '0;
      end else begin
         for (int f = 0; f < NCFG; f++)
            cfg_q[f] <= (cfg_q[f] & ~wsel[f]) | (wval & wsel[f]);
         stat_q <= (stat_q & ~(wsel[FT_STAT] & wval)) | evt;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int f = 0; f < NFEAT; f++)
         for (int i = 0; i < NPINS; i++)
            if (hit[f][i / WORD_BITS]) rd_word[i % WORD_BITS] = rd_word[i % WORD_BITS] | view[f][i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_en ? rd_word : '0;
   end

   assign rdata = rdata_q;
   assign oe    = cfg_q[FT_OE];
   assign dout  = cfg_q[FT_DATA];
   assign ien   = cfg_q[FT_IEN];
   assign pol   = cfg_q[FT_POL];
   assign typ   = cfg_q[FT_TYPE];
   assign stat  = stat_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS  = 57,
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned FEAT_BASE [NFEAT] = '{32'h00, 32'h08, 32'h18, 32'h38, 32'h40, 32'h48}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);
   localparam int unsigned NWORDS = (NPINS + WORD_BITS - 1) / WORD_BITS;
   localparam int unsigned SPAN   = NWORDS * 4;

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("gpio_bank_ctrl: NPINS out of range");
   end
   for (genvar a = 0; a < NFEAT; a++) begin : g_chk_a
      if ((FEAT_BASE[a] % 4) != 0 || (FEAT_BASE[a] + SPAN) > (1 << ADDR_W)) begin : g_bad_base
         $error("gpio_bank_ctrl: feature base misaligned or beyond address space");
      end
      for (genvar b = a + 1; b < NFEAT; b++) begin : g_chk_b
         if (!windows_apart(FEAT_BASE[a], FEAT_BASE[b], SPAN)) begin : g_overlap
            $error("gpio_bank_ctrl: feature windows overlap for this pin count");
         end
      end
   end

   logic [NPINS-1:0] lvl, lvl_d, evt;
   logic [NPINS-1:0] pol_q, typ_q, ien_q, stat_q;
   logic             irq_q;

   gpio_pin_sync #(.NPINS(NPINS)) u_sync (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .lvl(lvl), .lvl_d(lvl_d)
   );

   gpio_evt_detect #(.NPINS(NPINS)) u_det (
      .lvl(lvl), .lvl_d(lvl_d), .pol(pol_q), .typ(typ_q), .evt(evt)
   );

   gpio_bank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .FEAT_BASE(FEAT_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .evt(evt), .oe(pad_oe), .dout(pad_out),
      .ien(ien_q), .pol(pol_q), .typ(typ_q), .stat(stat_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_q & ien_q);
   end

   assign irq = irq_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int unsigned NPINS = 57
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [31:0]      rdata,
   input logic             irq,
   input logic [NPINS-1:0] stat,
   input logic [NPINS-1:0] ien
);
   // R8: a pending enabled pin raises the request on the next cycle
   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat & ien)) |=> irq);

   // R8: with nothing pending and enabled the request drops on the next cycle
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat & ien)) |=> !irq);

   // R7: a status bit only falls after a bus write
   p_stat_fall_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(stat) & ~stat)) |-> $past(wr_en));

   // R9: read data is zero in cycles that do not follow a read
   p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == 32'h0));
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
   .irq(irq), .stat(stat_q), .ien(ien_q)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
   localparam int NP = 40;
   localparam logic [8:0] A_OE = 9'h00, A_DATA = 9'h08, A_IEN = 9'h18,
                          A_POL = 9'h38, A_TYPE = 9'h40, A_STAT = 9'h48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [8:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe;
   logic          irq;
   int            compared = 0;
   int            mismatched = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(9)) u_gpio_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      tick(1);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, {32'h0, d}, {32'h0, exp});
   endtask

   function automatic logic [31:0] word_bit(input int p, input int w);
      return (p / 32 == w) ? (32'h1 << (p % 32)) : 32'h0;
   endfunction

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R2: reset state
      chk("R2 pad_oe", {24'h0, pad_oe}, 64'h0);
      chk("R2 pad_out", {24'h0, pad_out}, 64'h0);
      chk("R2 irq", {63'h0, irq}, 64'h0);
      foreach (A_OE[i]) ;
      rd_chk("R2 oe0", A_OE, 32'h0);
      rd_chk("R2 stat0", A_STAT, 32'h0);
      rd_chk("R2 ien1", A_IEN + 9'h4, 32'h0);
      rd_chk("R2 type0", A_TYPE, 32'h0);

      // R3 / R4: direction and data drive the pads; upper bits dropped
      wr(A_OE, 32'hA5A5_5A5A);
      chk("R3 pad_oe low", {24'h0, pad_oe}, {32'h0, 32'hA5A5_5A5A});
      wr(A_OE + 9'h4, 32'hFFFF_FFFF);
      chk("R3 pad_oe full", {24'h0, pad_oe}, {24'h0, 8'hFF, 32'hA5A5_5A5A});
      rd_chk("R4 oe1 upper bits zero", A_OE + 9'h4, 32'h0000_00FF);
      wr(A_DATA, 32'h1234_5678);
      wr(A_DATA + 9'h4, 32'hCDEF_0193);
      chk("R3 pad_out", {24'h0, pad_out}, {24'h0, 8'h93, 32'h1234_5678});
      rd_chk("R1 data0 readback", A_DATA, 32'h1234_5678);
      rd_chk("R4 data1 upper bits zero", A_DATA + 9'h4, 32'h0000_0093);
      wr(A_IEN, 32'h0F0F_F0F0);
      rd_chk("R1 ien0 readback", A_IEN, 32'h0F0F_F0F0);
      wr(A_POL + 9'h4, 32'h0000_0055);
      rd_chk("R1 pol1 readback", A_POL + 9'h4, 32'h0000_0055);
      wr(A_TYPE, 32'hDEAD_BEEF);
      rd_chk("R1 type0 readback", A_TYPE, 32'hDEAD_BEEF);
      // R4: unmapped and misaligned addresses read zero
      rd_chk("R4 gap 0x10", 9'h10, 32'h0);
      rd_chk("R4 stat word2 0x50", 9'h50, 32'h0);
      rd_chk("R4 misaligned 0x19", 9'h19, 32'h0);
      wr(9'h10, 32'hFFFF_FFFF);
      rd_chk("R4 gap write ignored", 9'h10, 32'h0);
      rd_chk("R4 gap write no alias", A_DATA, 32'h1234_5678);

      // restore quiet configuration
      wr(A_POL + 9'h4, 32'h0); wr(A_TYPE, 32'h0); wr(A_IEN, 32'h0);
      wr(A_OE, 32'h0); wr(A_OE + 9'h4, 32'h0);
      tick(4);
      wr(A_STAT, 32'hFFFF_FFFF); wr(A_STAT + 9'h4, 32'hFFFF_FFFF);
      tick(2);

      // R8: pending status with enable 0 keeps irq low
      pad_in[3] = 1'b1;
      tick(6);
      rd_chk("R6 level high sets status", A_STAT, 32'h8);
      chk("R8 disabled pin no irq", {63'h0, irq}, 64'h0);
      // R6: clear while level remains active leaves status set
      wr(A_STAT, 32'h8);
      rd_chk("R6 clear while active re-sets", A_STAT, 32'h8);
      pad_in[3] = 1'b0;
      tick(4);
      wr(A_STAT, 32'h8);
      rd_chk("R7 clear after level gone", A_STAT, 32'h0);

      // near-exhaustive sweep: every pin in every type/polarity mode
      wr(A_IEN, 32'hFFFF_FFFF); wr(A_IEN + 9'h4, 32'hFFFF_FFFF);
      for (int m = 0; m < 4; m++) begin
         bit tp, pl;
         string rq;
         tp = m[1]; pl = m[0];
         rq = tp ? "R5" : "R6";
         pad_in = pl ? '1 : '0;
         tick(4);
         wr(A_TYPE, tp ? 32'hFFFF_FFFF : 32'h0); wr(A_TYPE + 9'h4, tp ? 32'hFFFF_FFFF : 32'h0);
         wr(A_POL, pl ? 32'hFFFF_FFFF : 32'h0);  wr(A_POL + 9'h4, pl ? 32'hFFFF_FFFF : 32'h0);
         tick(4);
         wr(A_STAT, 32'hFFFF_FFFF); wr(A_STAT + 9'h4, 32'hFFFF_FFFF);
         tick(2);
         for (int p = 0; p < NP; p++) begin
            pad_in[p] = ~pl;
            tick(3);
            chk($sformatf("R8 irq not yet m%0d p%0d", m, p), {63'h0, irq}, 64'h0);
            tick(1);
            chk($sformatf("R8 irq due m%0d p%0d", m, p), {63'h0, irq}, 64'h1);
            rd_chk($sformatf("%s status set m%0d p%0d", rq, m, p), A_STAT + 9'(4 * (p / 32)), word_bit(p, p / 32));
            rd_chk($sformatf("R1 other word clear m%0d p%0d", m, p), A_STAT + 9'(4 * (1 - p / 32)), 32'h0);
            pad_in[p] = pl;
            tick(4);
            rd_chk($sformatf("%s sticky m%0d p%0d", rq, m, p), A_STAT + 9'(4 * (p / 32)), word_bit(p, p / 32));
            wr(A_STAT + 9'(4 * (p / 32)), ~word_bit(p, p / 32) & 32'h0);
            rd_chk($sformatf("R7 write zero no effect m%0d p%0d", m, p), A_STAT + 9'(4 * (p / 32)), word_bit(p, p / 32));
            wr(A_STAT + 9'(4 * (p / 32)), word_bit(p, p / 32));
            tick(1);
            chk($sformatf("R8 irq drops m%0d p%0d", m, p), {63'h0, irq}, 64'h0);
            rd_chk($sformatf("R7 cleared m%0d p%0d", m, p), A_STAT + 9'(4 * (p / 32)), 32'h0);
         end
      end

      // R5: in rising mode the falling edge alone sets nothing
      pad_in = '1;
      tick(4);
      wr(A_TYPE, 32'hFFFF_FFFF); wr(A_POL, 32'h0);
      tick(4);
      wr(A_STAT, 32'hFFFF_FFFF);
      tick(1);
      pad_in[7] = 1'b0;
      tick(6);
      rd_chk("R5 opposite edge ignored", A_STAT, 32'h0);
      chk("R8 no irq without event", {63'h0, irq}, 64'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule